// File: doc/BRIEF.md
# Global Character Unpack Stage

This stage sits on a wide cache-read path. It views the whole incoming line as one continuous bit string and spreads narrow characters into power-of-two container lanes. Six-bit characters each land in the low bits of their own byte lane. Nine-, ten- and fifteen-bit characters each land in the low bits of their own halfword lane. Characters are taken either from the left (most significant) end of the line or from the right (least significant) end.

The same stage also runs in reverse for the store path. In that direction it packs the low bits of each byte or halfword lane back into a contiguous character string. A bypass mode passes the line through untouched. One registered stage with a valid/ready handshake holds the result.

Top module: `line_char_expander`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Unpack with in_size=0 (6-bit characters): character k goes to the low 6 bits of byte lane k, and the top 2 bits of every byte lane are 0. There are W/8 characters.
- R3: Unpack with in_size=1, 2 or 3 (9-, 10- or 15-bit characters): character k goes to the low bits of 16-bit lane k, and the remaining high bits of that lane are 0. There are W/16 characters.
- R4: With in_from_right=0, character k occupies line bits [W-1-k*C -: C] and lane k occupies bits [W-1-k*Lw -: Lw]. C is the character width and Lw is the lane width.
- R5: With in_from_right=1, character k occupies bits [k*C +: C] and lane k occupies bits [k*Lw +: Lw].
- R6: On unpack, input bits outside the selected character string have no effect on the output.
- R7: With in_pack=1, the low C bits of lane k are written to character position k, using the same end and positions as R4/R5. Lane high bits are ignored, and output bits beyond the packed string are 0.
- R8: With in_bypass=1, the output line equals the input line, whatever the other selects are.
- R9: A line accepted on a clock edge (in_valid and in_ready both 1) appears with out_valid=1 after that edge. While out_valid=1 and out_ready=0, out_valid and out_line hold.
- R10: in_ready equals (not out_valid) or out_ready. A consumed output with no new acceptance leaves out_valid at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input line is offered |
| in_ready | output | 1 | Stage can take a line this cycle |
| in_line | input | W | Incoming line |
| in_size | input | 2 | Character size: 0=6, 1=9, 2=10, 3=15 bits |
| in_from_right | input | 1 | 1: characters start at the right end of the line |
| in_pack | input | 1 | 1: pack lanes into characters (store direction) |
| in_bypass | input | 1 | 1: pass the line through unchanged |
| out_valid | output | 1 | Output line is valid |
| out_ready | input | 1 | Consumer takes the output line |
| out_line | output | W | Expanded, packed or bypassed line |

## Verification
Every transformed line is due on the edge after its acceptance. It stays on the output until the consumer takes it, so the result is due one edge after the accepting edge and is compared when the consumer takes it. The bench drives inputs and samples the ports just after the falling edge. It pushes a behaviourally computed expected line whenever a handshake will occur at the next rising edge. In every cycle it checks that out_valid matches the count of lines in flight and that in_ready follows R10. Random backpressure tests the holding behaviour. A pair of lines that differ only in bits outside the character string must give identical results.

// File: rtl/lce_pkg.sv
// Package: shared encodings for the character unpack stage.
// Assumes the size code is two bits wide; codes map to 6, 9, 10 and 15-bit characters.
package lce_pkg;

    typedef enum logic [1:0] {
        CH6  = 2'd0,
        CH9  = 2'd1,
        CH10 = 2'd2,
        CH15 = 2'd3
    } char_size_e;

    localparam int NUM_SIZES = 4;

    // Character width in bits for a size code.
    function automatic int char_bits(input int code);
        case (code)
            0:       return 6;
            1:       return 9;
            2:       return 10;
            default: return 15;
        endcase
    endfunction

    // Container lane width in bits for a size code.
    function automatic int lane_bits(input int code);
        return (code == 0) ? 8 : 16;
    endfunction

endpackage

// File: rtl/lce_lane_map.sv
// Module: fixed wiring between a contiguous C-bit character string and L-bit lanes.
// It produces the unpack and pack results for both starting ends at once.
// Assumes W is a multiple of L and C < L, so that N*C < W.
module lce_lane_map #(
    parameter int W = 1024,
    parameter int C = 6,
    parameter int L = 8
) (
    input  logic [W-1:0] line_i,
    output logic [W-1:0] unp_right_o,
    output logic [W-1:0] unp_left_o,
    output logic [W-1:0] pak_right_o,
    output logic [W-1:0] pak_left_o
);
    localparam int N   = W / L;
    localparam int B   = N * C;
    localparam int PAD = W - B;
    localparam int HI  = L - C;

    logic [B-1:0] body_right;
    logic [B-1:0] body_left;

    for (genvar k = 0; k < N; k++) begin : g_lane
        // Unpack from the right end: character k goes to the low bits of lane k.
        assign unp_right_o[k*L +: L] = {{HI{1'b0}}, line_i[k*C +: C]};
        // Unpack from the left end: positions are counted down from the top bit.
        assign unp_left_o[W-1-k*L -: L] = {{HI{1'b0}}, line_i[W-1-k*C -: C]};
        // Pack from the right end: the low bits of lane k go to character k.
        assign body_right[k*C +: C] = line_i[k*L +: C];
        // Pack from the left end: the low bits of lane k go to character k from the top.
        assign body_left[B-1-k*C -: C] = line_i[W-1-k*L-HI -: C];
    end

    // Zero the unused remainder of the packed line, on the side away from the start end.
    assign pak_right_o = {{PAD{1'b0}}, body_right};
    assign pak_left_o  = {body_left, {PAD{1'b0}}};

endmodule

// File: rtl/lce_pipe_reg.sv
// Module: one-entry output register with a valid/ready handshake.
// Takes a new word when empty or when the held word leaves in the same cycle.
// Assumes a synchronous active-low reset.
module lce_pipe_reg #(
    parameter int W = 1024
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up_valid,
    output logic         up_ready,
    input  logic [W-1:0] up_data,
    output logic         dn_valid,
    input  logic         dn_ready,
    output logic [W-1:0] dn_data
);
    logic         full_q;
    logic [W-1:0] data_q;

    // Ready when nothing is held or when the held word is being taken.
    assign up_ready = !full_q || dn_ready;
    assign dn_valid = full_q;
    assign dn_data  = data_q;

    // Occupancy: reloads whenever the stage can take a word.
    always_ff @(posedge clk) begin
        if (!rst_n)        full_q <= 1'b0;
        else if (up_ready) full_q <= up_valid;
    end

    // Data capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)                     data_q <= '0;
        else if (up_valid && up_ready)  data_q <= up_data;
    end

endmodule

// File: rtl/line_char_expander.sv
// Module: the global character unpack/pack stage (top level).
// It builds the lane map for each character size and picks the result by size,
// direction, start end and bypass. The result goes through one handshake register.
// Assumes W is a multiple of 64. Selects are sampled together with in_line.
module line_char_expander #(
    parameter int W = 1024
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_line,
    input  logic [1:0]   in_size,
    input  logic         in_from_right,
    input  logic         in_pack,
    input  logic         in_bypass,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_line
);
    import lce_pkg::*;

    logic [W-1:0] unp_r [NUM_SIZES];
    logic [W-1:0] unp_l [NUM_SIZES];
    logic [W-1:0] pak_r [NUM_SIZES];
    logic [W-1:0] pak_l [NUM_SIZES];
    logic [W-1:0] next_line;

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        localparam int CW = char_bits(s);
        localparam int LW = lane_bits(s);
        lce_lane_map #(.W(W), .C(CW), .L(LW)) u_map (
            .line_i     (in_line),
            .unp_right_o(unp_r[s]),
            .unp_left_o (unp_l[s]),
            .pak_right_o(pak_r[s]),
            .pak_left_o (pak_l[s])
        );
    end

    // Result select: bypass first, then direction and start end, indexed by size.
    always_comb begin
        if (in_bypass)          next_line = in_line;
        else if (in_pack)       next_line = in_from_right ? pak_r[in_size] : pak_l[in_size];
        else                    next_line = in_from_right ? unp_r[in_size] : unp_l[in_size];
    end

    lce_pipe_reg #(.W(W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .up_valid(in_valid),
        .up_ready(in_ready),
        .up_data (next_line),
        .dn_valid(out_valid),
        .dn_ready(out_ready),
        .dn_data (out_line)
    );

endmodule

// File: rtl/lce_chk.sv
// Module: assertion checker for line_char_expander, attached by bind.
// It observes only the top-level ports.
module lce_chk #(
    parameter int W = 1024
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_ready,
    input logic [W-1:0] in_line,
    input logic [1:0]   in_size,
    input logic         in_from_right,
    input logic         in_pack,
    input logic         in_bypass,
    input logic         out_valid,
    input logic         out_ready,
    input logic [W-1:0] out_line
);
    logic took;
    assign took = in_valid && in_ready;

    // R10
    ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == (!out_valid || out_ready));

    // R9
    valid_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        took |=> out_valid);

    // R9
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_line)));

    // R10
    drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !took) |=> !out_valid);

    // R8
    bypass_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (took && in_bypass) |=> (out_line == $past(in_line)));

    // R2
    byte_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (took && !in_bypass && !in_pack && in_size == 2'd0)
        |=> (out_line[W-1 -: 2] == 2'b00 && out_line[7:6] == 2'b00));

endmodule

bind line_char_expander lce_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_line      (in_line),
    .in_size      (in_size),
    .in_from_right(in_from_right),
    .in_pack      (in_pack),
    .in_bypass    (in_bypass),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_line     (out_line)
);

// File: tb/line_char_expander_tb.sv
// Bench: a behavioural reference model with a queue of expected lines, compared every cycle.
module line_char_expander_tb;
    localparam int W = 256;
    localparam int LIMIT_CYCLES = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_line = '0;
    logic [1:0]   in_size = 2'd0;
    logic         in_from_right = 1'b0;
    logic         in_pack = 1'b0;
    logic         in_bypass = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [W-1:0] out_line;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    logic [W-1:0] exp_q [$];
    string        tag_q [$];
    logic [W-1:0] r6_first;

    always #5 clk = ~clk;

    line_char_expander #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_line(in_line), .in_size(in_size), .in_from_right(in_from_right),
        .in_pack(in_pack), .in_bypass(in_bypass), .out_valid(out_valid),
        .out_ready(out_ready), .out_line(out_line)
    );

    // Behavioural expectation, computed bit by bit from the requirements.
    function automatic logic [W-1:0] model(input logic [W-1:0] line, input int sz,
                                           input bit right, input bit pack, input bit byp);
        logic [W-1:0] res = '0;
        int c, l, n, cpos, lpos;
        if (byp) return line;
        c = (sz == 0) ? 6 : (sz == 1) ? 9 : (sz == 2) ? 10 : 15;
        l = (sz == 0) ? 8 : 16;
        n = W / l;
        for (int k = 0; k < n; k++) begin
            for (int b = 0; b < c; b++) begin
                cpos = right ? k*c + b : W - k*c - c + b;
                lpos = right ? k*l + b : W - k*l - l + b;
                if (pack) res[cpos] = line[lpos];
                else      res[lpos] = line[cpos];
            end
        end
        return res;
    endfunction

    function automatic logic [W-1:0] rnd_line();
        logic [W-1:0] v;
        for (int i = 0; i < W/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, sample, score, record the acceptance.
    task automatic step(input bit v, input logic [W-1:0] line, input int sz,
                        input bit right, input bit pack, input bit byp, input bit ordy);
        string t;
        @(negedge clk);
        in_valid = v; in_line = line; in_size = sz[1:0];
        in_from_right = right; in_pack = pack; in_bypass = byp; out_ready = ordy;
        #1;
        check("R9 out_valid vs lines in flight", {{(W-1){1'b0}}, out_valid},
              {{(W-1){1'b0}}, (exp_q.size() > 0)});
        check("R10 in_ready", {{(W-1){1'b0}}, in_ready},
              {{(W-1){1'b0}}, (!out_valid || out_ready)});
        if (out_valid && out_ready && exp_q.size() > 0) begin
            check(tag_q[0], out_line, exp_q[0]);
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
        end
        if (v && in_ready) begin
            if (byp)          t = "R8 bypass";
            else if (pack)    t = right ? "R7 pack R5" : "R7 pack R4";
            else if (sz == 0) t = right ? "R2 unpack R5" : "R2 unpack R4";
            else              t = right ? "R3 unpack R5" : "R3 unpack R4";
            exp_q.push_back(model(line, sz, right, pack, byp));
            tag_q.push_back(t);
        end
    endtask

    task automatic drain();
        int guard = 0;
        while (exp_q.size() > 0 && guard < 50) begin
            step(0, '0, 0, 0, 0, 0, 1);
            guard++;
        end
    endtask

    always @(posedge clk) cycles++;

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        wait (cycles >= LIMIT_CYCLES || done);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=<%0d cycles", cycles, LIMIT_CYCLES);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state.
        check("R1 out_valid after reset", {{(W-1){1'b0}}, out_valid}, '0);
        check("R1 in_ready after reset", {{(W-1){1'b0}}, in_ready}, {{(W-1){1'b0}}, 1'b1});
        @(negedge clk); rst_n = 1'b1;

        // R2, R3, R4, R5, R7: every size, both ends, both directions, several patterns.
        for (int sz = 0; sz < 4; sz++)
            for (int rt = 0; rt < 2; rt++)
                for (int pk = 0; pk < 2; pk++) begin
                    step(1, '1, sz, rt[0], pk[0], 0, 1);
                    step(1, rnd_line(), sz, rt[0], pk[0], 0, 1);
                    step(1, {W/8{8'hA5}}, sz, rt[0], pk[0], 0, 1);
                end
        drain();

        // R8: bypass ignores the other selects.
        for (int i = 0; i < 4; i++) step(1, rnd_line(), i, i[0], i[1], 1, 1);
        drain();

        // R6: the same characters with different bits outside the string give the same result.
        for (int sz = 0; sz < 4; sz++)
            for (int rt = 0; rt < 2; rt++) begin
                logic [W-1:0] base, alt, mask;
                base = rnd_line();
                mask = model(model('1, sz, rt[0], 0, 0), sz, rt[0], 1, 0);
                alt  = (base & mask) | (rnd_line() & ~mask);
                step(1, base, sz, rt[0], 0, 0, 1);
                drain();
                r6_first = out_line;
                step(1, alt, sz, rt[0], 0, 0, 1);
                drain();
                check("R6 outside bits ignored", out_line, r6_first);
            end

        // R9, R10: random traffic under random backpressure.
        for (int i = 0; i < 300; i++)
            step($urandom_range(0, 3) != 0, rnd_line(), $urandom_range(0, 3),
                 $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 7) == 0,
                 $urandom_range(0, 2) != 0);
        drain();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule